// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the transfer engine of a four-channel DMA controller. A companion register interface holds the software view. It passes in the per-channel mode fields, the controller-disable and rotating-priority command bits, and load, mask-write and software-request strobes. The sequencer holds each channel's base and current address, its base and current count, its mask bit, its software request bit and its terminal-count flag.

On each idle cycle the sequencer gathers the channels that are asking for service. A channel asks when its hardware request is high and its mask is clear, or when its software request bit is set. The sequencer grants one of them and then moves one byte per clock. For each byte it drives DACK, the memory address and a one-cycle read or write strobe. It then steps the address and count. A transfer ends on count wrap or on an external end-of-process input. At the end, the channel either reloads itself from its base registers or masks itself off. Bus arbitration with a host and the data path are outside this block.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, DACK is all zero, both strobes are low, every mask bit is set, and every terminal-count flag and software request is clear.
- R2: A channel is pending when its hardware request is high with its mask clear, or when its software request bit is set (the mask does not matter for the software request). `req_flags_o` shows the pending vector. No grant is made while `ctl_disable_i` is high.
- R3: With `rotate_i` low, the lowest-numbered pending channel wins. With `rotate_i` high, the search starts just after the last granted channel, so that channel ranks lowest. Channel 0 ranks highest after reset.
- R4: The grant follows one clock after a pending channel is seen in the idle state. During a grant, each clock moves one byte at the channel's current address. Each channel's 6-bit mode field holds mode-byte bits 7:2. Field bit 3 = 0 increments the address after the byte, and 1 decrements it.
- R5: Field bits 1:0 select the strobe. 01 asserts `mem_wr_o`, 10 asserts `mem_rd_o`, and 00 (verify) or 11 asserts neither. A strobe is only ever asserted alongside DACK.
- R6: The current count decrements after each byte. The byte moved while the count is 0 is the last one, so a programmed count of N moves N+1 bytes.
- R7: Field bits 5:4 = 01 (single) release DACK after every byte. The channel then waits one idle cycle and is arbitrated again.
- R8: Field bits 5:4 = 10 (block) keep DACK until the transfer ends, even if the hardware request drops.
- R9: Field bits 5:4 = 00 or 11 (demand) keep the grant only while the request is high. When it drops, the grant is released and the address and count are kept. When it returns, the transfer resumes from where it stopped.
- R10: When `eop_i` is high during a byte, that byte is the last one.
- R11: The last byte pulses `tc_pulse_o`, sets that channel's terminal-count flag and clears its software request. DACK is low on the next clock. `flag_clr_i` clears all flags, but a flag being set in the same cycle wins.
- R12: At the end, a channel with field bit 2 clear sets its own mask bit. A channel with bit 2 set keeps its mask clear and reloads its current address and count from its base values.
- R13: DACK is never asserted for more than one channel at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq_i | input | NCH | Hardware request per channel |
| eop_i | input | 1 | External end of process, ends the transfer after the current byte |
| ctl_disable_i | input | 1 | Command bit: blocks new grants |
| rotate_i | input | 1 | Command bit: rotating priority |
| mode_i | input | 6*NCH | Per-channel mode field (mode byte bits 7:2); channel k at [6k+5:6k] |
| load_i | input | NCH | Load base and current address and count for a channel |
| base_addr_i | input | AW | Address value to load |
| base_cnt_i | input | CW | Count value to load |
| mask_wr_i | input | 1 | Write all mask bits |
| mask_data_i | input | NCH | Mask value written by `mask_wr_i` |
| sreq_set_i | input | NCH | Set software request bits |
| sreq_clr_i | input | NCH | Clear software request bits |
| flag_clr_i | input | 1 | Clear all terminal-count flags |
| dack_o | output | NCH | Acknowledge for the channel being serviced |
| mem_addr_o | output | AW | Address of the current byte (zero when idle) |
| mem_rd_o | output | 1 | One-cycle read-from-memory strobe |
| mem_wr_o | output | 1 | One-cycle write-to-memory strobe |
| tc_pulse_o | output | 1 | High during the last byte of a transfer |
| tc_flags_o | output | NCH | Terminal-count flags |
| req_flags_o | output | NCH | Pending request vector |
| mask_o | output | NCH | Current mask bits |

## Verification
Every cycle, the assertions check the invariants that hold whatever was programmed: DACK is one-hot or zero, the two strobes never appear together, and no strobe appears without DACK. They also check that a terminal-count pulse sets the flag of the acknowledged channel and drops DACK, and that no grant starts while the controller is disabled. Other behaviours depend on the programmed mode and on how the requests are timed, and only the bench's scenarios show them. These are the address sequences up or down, the N+1 byte count, single-mode release versus block-mode hold, and demand-mode pause and resume at the same address. The scenarios also cover the end of a transfer by external end-of-process, self-masking versus autoinitialize reload, and the grant order under fixed and rotating priority.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SVC_DEMAND  = 2'b00,
    SVC_SINGLE  = 2'b01,
    SVC_BLOCK   = 2'b10,
    SVC_DEMAND2 = 2'b11
  } svc_e;

  typedef enum logic [1:0] {
    XT_VERIFY = 2'b00,
    XT_WRITE  = 2'b01,
    XT_READ   = 2'b10,
    XT_NONE   = 2'b11
  } xtype_e;

  // Per-channel mode field, bits 7:2 of the mode byte.
  typedef struct packed {
    svc_e   svc;
    logic   dec;
    logic   autoinit;
    xtype_e xtype;
  } chan_mode_t;

  localparam int MODE_W = $bits(chan_mode_t);

  // Keep the grant after a non-final byte?
  function automatic logic svc_continue(chan_mode_t m, logic still_req);
    case (m.svc)
      SVC_BLOCK:  return 1'b1;
      SVC_SINGLE: return 1'b0;
      default:    return still_req;
    endcase
  endfunction

  function automatic logic strobe_rd(chan_mode_t m);
    return m.xtype == XT_READ;
  endfunction

  function automatic logic strobe_wr(chan_mode_t m);
    return m.xtype == XT_WRITE;
  endfunction

endpackage

// File: rtl/dma_seq_chan.sv
`timescale 1ns/1ps
module dma_seq_chan #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] base_cnt_i,
  input  logic          mask_wr_i,
  input  logic          mask_bit_i,
  input  logic          sreq_set_i,
  input  logic          sreq_clr_i,
  input  logic          flag_clr_i,
  input  logic          step_i,
  input  logic          end_i,
  input  logic          dec_i,
  input  logic          auto_i,
  output logic [AW-1:0] cur_addr_o,
  output logic          cnt_zero_o,
  output logic          mask_o,
  output logic          sreq_o,
  output logic          tc_flag_o
);

  logic [AW-1:0] base_addr_q, cur_addr_q;
  logic [CW-1:0] base_cnt_q, cur_cnt_q;
  logic          mask_q, sreq_q, tcf_q;

  function automatic logic [AW-1:0] step_addr(logic [AW-1:0] a, logic down);
    return down ? a - AW'(1) : a + AW'(1);
  endfunction

  wire finish = step_i & end_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
    end else if (load_i) begin
      base_addr_q <= base_addr_i;
      base_cnt_q  <= base_cnt_i;
      cur_addr_q  <= base_addr_i;
      cur_cnt_q   <= base_cnt_i;
    end else if (step_i) begin
      if (finish && auto_i) begin
        cur_addr_q <= base_addr_q;
        cur_cnt_q  <= base_cnt_q;
      end else begin
        cur_addr_q <= step_addr(cur_addr_q, dec_i);
        cur_cnt_q  <= cur_cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
      sreq_q <= 1'b0;
      tcf_q  <= 1'b0;
    end else begin
      if (finish && !auto_i) mask_q <= 1'b1;
      else if (mask_wr_i)    mask_q <= mask_bit_i;

      if (finish)          sreq_q <= 1'b0;
      else if (sreq_set_i) sreq_q <= 1'b1;
      else if (sreq_clr_i) sreq_q <= 1'b0;

      if (finish)          tcf_q <= 1'b1;
      else if (flag_clr_i) tcf_q <= 1'b0;
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cnt_zero_o = (cur_cnt_q == '0);
  assign mask_o     = mask_q;
  assign sreq_o     = sreq_q;
  assign tc_flag_o  = tcf_q;

endmodule

// File: rtl/dma_seq_arb.sv
`timescale 1ns/1ps
module dma_seq_arb #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] pend_i,
  input  logic [CHW-1:0] last_i,
  input  logic           rotate_i,
  output logic           valid_o,
  output logic [CHW-1:0] pick_o
);

  always_comb begin
    valid_o = 1'b0;
    pick_o  = '0;
    for (int off = 0; off < NCH; off++) begin
      int idx;
      idx = rotate_i ? (int'(last_i) + 1 + off) % NCH : off;
      if (!valid_o && pend_i[idx]) begin
        valid_o = 1'b1;
        pick_o  = CHW'(idx);
      end
    end
  end

endmodule

// File: rtl/dma_xfer_seq.sv
`timescale 1ns/1ps
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    dreq_i,
  input  logic              eop_i,
  input  logic              ctl_disable_i,
  input  logic              rotate_i,
  input  logic [6*NCH-1:0]  mode_i,
  input  logic [NCH-1:0]    load_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic [CW-1:0]     base_cnt_i,
  input  logic              mask_wr_i,
  input  logic [NCH-1:0]    mask_data_i,
  input  logic [NCH-1:0]    sreq_set_i,
  input  logic [NCH-1:0]    sreq_clr_i,
  input  logic              flag_clr_i,
  output logic [NCH-1:0]    dack_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              tc_pulse_o,
  output logic [NCH-1:0]    tc_flags_o,
  output logic [NCH-1:0]    req_flags_o,
  output logic [NCH-1:0]    mask_o
);

  chan_mode_t    mode   [NCH];
  logic [AW-1:0] cur_addr [NCH];
  logic [NCH-1:0] cnt_zero, mask_v, sreq_v, tcf_v, step_v;

  logic           busy_q;
  logic [CHW-1:0] act_q, last_q;

  // Named internal events
  logic           arb_valid;
  logic [CHW-1:0] arb_pick;
  logic [NCH-1:0] pending;
  logic           grant_go;
  logic           xfer_end;
  logic           keep_going;
  chan_mode_t     act_mode;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign mode[k]   = chan_mode_t'(mode_i[MODE_W*k +: MODE_W]);
    assign step_v[k] = busy_q && (act_q == CHW'(k));

    dma_seq_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_i[k]),
      .base_addr_i (base_addr_i),
      .base_cnt_i  (base_cnt_i),
      .mask_wr_i   (mask_wr_i),
      .mask_bit_i  (mask_data_i[k]),
      .sreq_set_i  (sreq_set_i[k]),
      .sreq_clr_i  (sreq_clr_i[k]),
      .flag_clr_i  (flag_clr_i),
      .step_i      (step_v[k]),
      .end_i       (xfer_end),
      .dec_i       (mode[k].dec),
      .auto_i      (mode[k].autoinit),
      .cur_addr_o  (cur_addr[k]),
      .cnt_zero_o  (cnt_zero[k]),
      .mask_o      (mask_v[k]),
      .sreq_o      (sreq_v[k]),
      .tc_flag_o   (tcf_v[k])
    );
  end

  assign pending = (dreq_i & ~mask_v) | sreq_v;

  dma_seq_arb #(.NCH(NCH)) u_arb (
    .pend_i   (pending),
    .last_i   (last_q),
    .rotate_i (rotate_i),
    .valid_o  (arb_valid),
    .pick_o   (arb_pick)
  );

  assign act_mode   = mode[act_q];
  assign grant_go   = !busy_q && !ctl_disable_i && arb_valid;
  assign xfer_end   = busy_q && (cnt_zero[act_q] || eop_i);
  assign keep_going = !xfer_end &&
                      svc_continue(act_mode, dreq_i[act_q] | sreq_v[act_q]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= '0;
      last_q <= CHW'(NCH - 1);
    end else if (busy_q) begin
      busy_q <= keep_going;
    end else if (grant_go) begin
      busy_q <= 1'b1;
      act_q  <= arb_pick;
      last_q <= arb_pick;
    end
  end

  assign dack_o      = step_v;
  assign mem_addr_o  = busy_q ? cur_addr[act_q] : '0;
  assign mem_rd_o    = busy_q && strobe_rd(act_mode);
  assign mem_wr_o    = busy_q && strobe_wr(act_mode);
  assign tc_pulse_o  = xfer_end;
  assign tc_flags_o  = tcf_v;
  assign req_flags_o = pending;
  assign mask_o      = mask_v;

endmodule

// File: rtl/dma_xfer_seq_chk.sv
`timescale 1ns/1ps
module dma_xfer_seq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] dack_o,
  input logic           mem_rd_o,
  input logic           mem_wr_o,
  input logic           tc_pulse_o,
  input logic [NCH-1:0] tc_flags_o,
  input logic           ctl_disable_i
);

  AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_o)); // R13

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o)); // R5

  AST_STROBE_WITH_DACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> (dack_o != '0)); // R5

  AST_TC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse_o |=> ((tc_flags_o & $past(dack_o)) == $past(dack_o))); // R11

  AST_TC_DROPS_DACK: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse_o |=> (dack_o == '0)); // R11

  AST_NO_GRANT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((dack_o == '0) && ctl_disable_i) |=> (dack_o == '0)); // R2

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.NCH(NCH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dack_o        (dack_o),
  .mem_rd_o      (mem_rd_o),
  .mem_wr_o      (mem_wr_o),
  .tc_pulse_o    (tc_pulse_o),
  .tc_flags_o    (tc_flags_o),
  .ctl_disable_i (ctl_disable_i)
);

// File: tb/dma_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb_top;

  localparam int NCH = 4;
  localparam int AW  = 16;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] dreq = '0;
  logic eop = 1'b0, dis = 1'b0, rot = 1'b0;
  logic [6*NCH-1:0] mode = '0;
  logic [NCH-1:0] load = '0;
  logic [AW-1:0] baddr = '0;
  logic [CW-1:0] bcnt = '0;
  logic mwr = 1'b0;
  logic [NCH-1:0] mdata = '0, sset = '0, sclr = '0;
  logic fclr = 1'b0;

  logic [NCH-1:0] dack, tcf, reqf, mask;
  logic [AW-1:0] maddr;
  logic mrd, mwr_s, tcp;

  always #4 clk = ~clk;

  dma_xfer_seq #(.NCH(NCH), .AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dreq_i(dreq), .eop_i(eop),
    .ctl_disable_i(dis), .rotate_i(rot), .mode_i(mode), .load_i(load),
    .base_addr_i(baddr), .base_cnt_i(bcnt), .mask_wr_i(mwr),
    .mask_data_i(mdata), .sreq_set_i(sset), .sreq_clr_i(sclr),
    .flag_clr_i(fclr), .dack_o(dack), .mem_addr_o(maddr),
    .mem_rd_o(mrd), .mem_wr_o(mwr_s), .tc_pulse_o(tcp),
    .tc_flags_o(tcf), .req_flags_o(reqf), .mask_o(mask)
  );

  int errs = 0, checks = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Byte monitor, samples at the falling edge
  logic [AW-1:0] lg_addr [64];
  int  lg_ch [64];
  logic lg_rd [64], lg_wr [64];
  int n_log = 0, n_grant = 0, n_tc = 0, n_strobe = 0;
  logic [NCH-1:0] prev_dack = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dack != '0 && n_log < 64) begin
        lg_addr[n_log] = maddr;
        lg_rd[n_log] = mrd;
        lg_wr[n_log] = mwr_s;
        for (int i = 0; i < NCH; i++) if (dack[i]) lg_ch[n_log] = i;
        n_log++;
        if (prev_dack == '0) n_grant++;
      end
      if (tcp) n_tc++;
      if (mrd || mwr_s) n_strobe++;
    end
    prev_dack = dack;
  end

  task automatic clear_log();
    n_log = 0; n_grant = 0; n_tc = 0; n_strobe = 0;
  endtask

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; dreq = '0; eop = 1'b0; dis = 1'b0; rot = 1'b0;
    load = '0; mwr = 1'b0; sset = '0; sclr = '0; fclr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    clear_log();
  endtask

  // fld = {svc[1:0], dec, autoinit, type[1:0]}
  task automatic prog(int ch, logic [AW-1:0] a, logic [CW-1:0] c, logic [5:0] fld);
    mode[6*ch +: 6] = fld;
    baddr = a; bcnt = c; load[ch] = 1'b1;
    step(1);
    load = '0;
  endtask

  task automatic set_mask(logic [NCH-1:0] m);
    mdata = m; mwr = 1'b1;
    step(1);
    mwr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 dack", dack, 0);
    check("R1 mask", mask, 4'hF);
    check("R1 flags", tcf, 0);
    check("R1 strobes", {mrd, mwr_s}, 0);
    check("R1 req", reqf, 0);
  endtask

  task automatic t_single();
    do_reset();
    prog(1, 16'h1000, 16'd2, 6'b01_0_0_01);
    set_mask(4'b1101);
    clear_log();
    dreq[1] = 1'b1;
    step(20);
    check("R6 byte count", n_log, 3);
    check("R4 addr0", lg_addr[0], 16'h1000);
    check("R4 addr2", lg_addr[2], 16'h1002);
    check("R5 write strobe", {lg_wr[1], lg_rd[1]}, 2'b10);
    check("R7 grants", n_grant, 3);
    check("R11 tc pulses", n_tc, 1);
    check("R11 tc flag", tcf[1], 1);
    check("R12 self mask", mask[1], 1);
    check("R2 masked request ignored", reqf[1], 0);
    dreq = '0;
    fclr = 1'b1; step(1); fclr = 1'b0;
    check("R11 flag clear", tcf, 0);
  endtask

  task automatic t_block_auto();
    do_reset();
    prog(2, 16'h2005, 16'd3, 6'b10_1_1_10);
    set_mask(4'b1011);
    clear_log();
    dreq[2] = 1'b1; step(1); dreq[2] = 1'b0;
    step(10);
    check("R8 block bytes", n_log, 4);
    check("R8 block grants", n_grant, 1);
    check("R4 dec addr last", lg_addr[3], 16'h2002);
    check("R5 read strobe", {lg_wr[0], lg_rd[0]}, 2'b01);
    check("R12 mask kept clear", mask[2], 0);
    check("R11 tc flag", tcf[2], 1);
    clear_log();
    dreq[2] = 1'b1; step(1); dreq[2] = 1'b0;
    step(10);
    check("R12 reload addr", lg_addr[0], 16'h2005);
    check("R12 reload count", n_log, 4);
  endtask

  task automatic t_sreq_verify();
    do_reset();
    prog(3, 16'h3000, 16'd0, 6'b01_0_0_00);
    clear_log();
    sset[3] = 1'b1; step(1); sset = '0;
    check("R2 sreq pending while masked", reqf[3], 1);
    check("R4 no dack before grant", dack, 0);
    step(6);
    check("R6 count zero one byte", n_log, 1);
    check("R5 verify no strobe", n_strobe, 0);
    check("R11 sreq cleared", reqf[3], 0);
    check("R11 tc flag", tcf[3], 1);
  endtask

  task automatic t_demand();
    do_reset();
    prog(0, 16'h0100, 16'd9, 6'b00_0_0_01);
    set_mask(4'b1110);
    clear_log();
    dreq[0] = 1'b1; step(3); dreq[0] = 1'b0;
    step(5);
    check("R9 paused bytes", n_log, 3);
    check("R9 no tc at pause", tcf[0], 0);
    dreq[0] = 1'b1; step(20); dreq[0] = 1'b0;
    check("R9 total bytes", n_log, 10);
    check("R9 resume addr", lg_addr[3], 16'h0103);
    check("R6 last addr", lg_addr[9], 16'h0109);
    check("R9 grants", n_grant, 2);
    check("R11 tc flag", tcf[0], 1);
  endtask

  task automatic t_eop();
    do_reset();
    prog(0, 16'h0400, 16'h00FF, 6'b10_0_0_01);
    set_mask(4'b1110);
    clear_log();
    dreq[0] = 1'b1; step(1); dreq[0] = 1'b0;
    while (n_log < 3) step(1);
    eop = 1'b1; step(1); eop = 1'b0;
    step(5);
    check("R10 eop bytes", n_log, 3);
    check("R10 eop tc flag", tcf[0], 1);
    check("R12 eop self mask", mask[0], 1);
  endtask

  task automatic t_priority(logic rotate, int e0, int e1, int e2, int e3, string tag);
    do_reset();
    rot = rotate;
    prog(0, 16'h0000, 16'd1, 6'b01_0_0_01);
    prog(1, 16'h0010, 16'd1, 6'b01_0_0_01);
    set_mask(4'b1100);
    clear_log();
    dreq = 4'b0011;
    step(20);
    dreq = '0;
    check({tag, " count"}, n_log, 4);
    check({tag, " order"}, {lg_ch[0][3:0], lg_ch[1][3:0], lg_ch[2][3:0], lg_ch[3][3:0]},
          {e0[3:0], e1[3:0], e2[3:0], e3[3:0]});
  endtask

  task automatic t_disable();
    do_reset();
    dis = 1'b1;
    prog(0, 16'h0800, 16'd1, 6'b01_0_0_01);
    set_mask(4'b1110);
    clear_log();
    dreq[0] = 1'b1;
    step(10);
    check("R2 disabled no grant", n_log, 0);
    dis = 1'b0;
    step(10);
    dreq = '0;
    check("R2 enabled grants", n_log, 2);
  endtask

  bit done = 0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_single();
    t_block_auto();
    t_sreq_verify();
    t_demand();
    t_eop();
    t_priority(1'b0, 0, 0, 1, 1, "R3 fixed");
    t_priority(1'b1, 0, 1, 0, 1, "R3 rotating");
    t_disable();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule